// File: doc/BRIEF.md
# Row-Column Transpose Buffer

This block sits between the row pass and the column pass of a two-dimensional FFT on a 16 by 16 frame of complex samples. Results from the row transform arrive as a stream qualified by a valid flag. Each accepted sample is stored at the next sequential location of a 256-entry memory. After a frame has been collected, the block reads the memory back so that each column of the frame comes out as 16 consecutive samples. These samples can feed the next transform pass directly.

Each sample is a 64-bit word. The real part is in bits 63:32 and the imaginary part is in bits 31:0. The block passes the word through without changing it. Collection ends when the valid flag falls. The block then reads all 256 entries in column order, pulses a completion flag, and returns to collecting.

Top module: `xpose_buf`

## Requirements
- R1: A synchronous active-low reset clears the phase, both address counters and both enables. While `rst_n` is low and on the cycle after it, `rd_en`, `rd_valid` and `frame_done` are low.
- R2: During the collect phase, every cycle with `in_valid` high stores `in_data` at the next sequential address, starting from 0. Sample k therefore lands at row k/16, column k%16, and the address is row*16+column.
- R3: A stored word is returned bit for bit on `rd_data`, with the real part in bits 63:32 and the imaginary part in bits 31:0.
- R4: If `in_valid` was high in cycle t-1 and is low in cycle t, `rd_en` is high from cycle t+1. Before that it is low.
- R5: The n-th read address (counting from 0) is {n%16, n/16}. The upper nibble is the row and steps every read cycle. The lower nibble is the column and steps when the row wraps from 15.
- R6: `rd_en` stays high for exactly 256 consecutive cycles per frame.
- R7: `rd_valid` is high one cycle after each cycle with `rd_en` high. In that cycle `rd_data` holds the word stored at the address issued in the previous cycle.
- R8: `frame_done` is a one-cycle pulse that coincides with the 256th `rd_valid`. After it the block collects a new frame from address 0.
- R9: Valid samples beyond the 256th in a frame, and valid samples during the read phase, are not stored. The readout of the current frame is unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Row-pass sample valid |
| in_data | input | 64 | Sample, real part in 63:32, imaginary part in 31:0 |
| rd_en | output | 1 | Read phase active; an address is issued this cycle |
| rd_addr | output | 8 | Read address {row, column} |
| rd_valid | output | 1 | `rd_data` holds a sample |
| rd_data | output | 64 | Sample read back in column order |
| frame_done | output | 1 | One-cycle pulse with the last sample of a frame |

## Verification
The bench checks every one of the 256 read addresses and data words across several data patterns. A swapped nibble order, or a column that steps on the wrong row, would appear as a mismatch in the first column. It feeds four extra samples at the end of one frame and five samples early in a read phase. A buffer that wrapped its write pointer would then corrupt entries that are read later. It also checks the exact cycle of the phase change, the 256-cycle length of the read phase, and the alignment of the completion pulse. Any off-by-one in the falling-edge detection or the end count shifts these by a cycle.

// File: rtl/xpose_buf.sv
module xpose_buf #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int DW    = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DW-1:0]          in_data,
  output logic                   rd_en,
  output logic [ROW_W+COL_W-1:0] rd_addr,
  output logic                   rd_valid,
  output logic [DW-1:0]          rd_data,
  output logic                   frame_done
);
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;

  logic             rd_phase;
  logic             v_q;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [DW-1:0]    wr_data;
  logic [AW:0]      wr_cnt;
  logic [ROW_W-1:0] rd_row;
  logic [COL_W-1:0] rd_col;
  logic [DW-1:0]    rd_q;
  logic [DW-1:0]    mem [DEPTH];

  wire wr_full  = wr_cnt[AW];
  wire last_rd  = (&rd_row) & (&rd_col);

  assign rd_en   = rd_phase;
  assign rd_addr = {rd_row, rd_col};
  assign rd_data = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_phase   <= 1'b0;
      v_q        <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_cnt     <= '0;
      rd_row     <= '0;
      rd_col     <= '0;
      rd_valid   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      v_q        <= in_valid;
      rd_valid   <= rd_phase;
      frame_done <= 1'b0;
      wr_en      <= 1'b0;
      wr_data    <= in_data;
      if (!rd_phase) begin
        if (in_valid && !wr_full) begin
          wr_en   <= 1'b1;
          wr_addr <= wr_cnt[AW-1:0];
          wr_cnt  <= wr_cnt + 1'b1;
        end
        if (v_q && !in_valid) rd_phase <= 1'b1;
      end else begin
        rd_row <= rd_row + 1'b1;
        if (&rd_row) rd_col <= rd_col + 1'b1;
        if (last_rd) begin
          rd_phase   <= 1'b0;
          frame_done <= 1'b1;
          wr_cnt     <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!rd_en && !rd_valid && !frame_done));

  p_wr_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

  p_start_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> ($past(v_q) && !$past(in_valid)));

  p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr[AW-1:COL_W] == $past(rd_addr[AW-1:COL_W]) + 1'b1));

  p_end_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_en) |-> (&$past(rd_addr)));

  p_valid_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |=> rd_valid);

  p_done_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (rd_valid && !rd_en));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_en);
endmodule

// File: tb/sim_xpose_buf.sv
`timescale 1ns / 1ps
module sim_xpose_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        frame_done;

  int checks = 0;
  int fails  = 0;

  xpose_buf u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .frame_done(frame_done)
  );

  always #2 clk = ~clk;

  function automatic logic [63:0] pat(input logic [31:0] seed, input int idx);
    logic [31:0] re, im;
    re = seed ^ (32'(idx) * 32'h9E37_79B9);
    im = ~seed + 32'(idx) * 32'h0001_0003;
    return {re, im};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(!rd_en && !rd_valid && !frame_done, "R1 outputs in reset",
          {rd_en, rd_valid, frame_done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_en && !rd_valid && !frame_done, "R1 outputs after reset",
          {rd_en, rd_valid, frame_done}, 0);
  endtask

  task automatic run_frame(input logic [31:0] seed, input int extra, input bit junk);
    int n_iss, n_val, r, c;
    for (int i = 0; i < 256 + extra; i++) begin
      in_valid = 1'b1;
      in_data  = (i < 256) ? pat(seed, i) : ~pat(seed, i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_data  = '0;
    check(!rd_en, "R4 rd_en low before falling edge seen", rd_en, 0);
    @(negedge clk);
    check(rd_en, "R4 rd_en high after falling edge", rd_en, 1);
    n_iss = 0;
    n_val = 0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (rd_en) begin
        check(rd_addr == 8'((n_iss % 16) * 16 + n_iss / 16), "R5 read address",
              rd_addr, (n_iss % 16) * 16 + n_iss / 16);
        n_iss++;
      end
      if (rd_valid) begin
        r = n_val % 16;
        c = n_val / 16;
        check(rd_data == pat(seed, r * 16 + c), "R7 R3 R2 R9 read data",
              rd_data, pat(seed, r * 16 + c));
        check(frame_done == (n_val == 255), "R8 done alignment", frame_done, n_val == 255);
        n_val++;
      end
      if (frame_done) break;
      if (junk && cyc < 5) begin
        in_valid = 1'b1;
        in_data  = 64'hDEAD_BEEF_0BAD_F00D ^ 64'(cyc);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(n_iss == 256, "R6 read cycles", n_iss, 256);
    check(n_val == 256, "R7 valid count", n_val, 256);
    check(!rd_en, "R6 rd_en low at end", rd_en, 0);
    @(negedge clk);
    check(!frame_done && !rd_en && !rd_valid, "R8 done one cycle",
          {frame_done, rd_en, rd_valid}, 0);
  endtask

  task automatic t_basic();      run_frame(32'h0000_0000, 0, 0); endtask
  task automatic t_patterns();   run_frame(32'hA5A5_5A5A, 0, 0); run_frame(32'hFFFF_FFFF, 0, 0); endtask
  task automatic t_overflow();   run_frame(32'h1234_5678, 4, 0); endtask
  task automatic t_read_junk();  run_frame(32'h0F0F_3C3C, 0, 1); endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 256; i++) begin
      in_valid = 1'b1; in_data = pat(32'h7777_0000, i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    check(rd_en, "R1 read phase active before reset", rd_en, 1);
    do_reset();
    run_frame(32'h2468_ACE0, 0, 0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_basic();
    t_patterns();
    t_overflow();
    t_read_junk();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule